// File: doc/BRIEF.md
# Masked Character Compare Unit

The unit holds two status toggles that report how one character of an eight-character register compares with the character in the same position of a memory word. A select character picks the position, and a mask character picks which of the six data bits of that character take part. Each character is seven bits wide. Bits 5..0 are data (numeric and zone bits) and bit 6 is parity, which never takes part. Character position p occupies word bits [7p+6:7p].

A one-cycle start strobe clears both toggles and loads them with the result in the same edge. The "equal" toggle reports that every masked bit matches. The "complement" toggle reports that every masked bit differs. If the mask is empty, both toggles are set. If the bits are mixed or the position is invalid, both stay cleared. The toggles keep their values until the next start, and a done pulse marks each evaluation.

Top module: `char_cmp_unit`

## Requirements
- R1: While rst_ni is low, and after it is released with no start, eq_o, cmp_o and done_o are 0.
- R2: The position is the unsigned value of zsel_i[3:0]. The same position is used in both reg_i and mem_i, and zsel_i[6:4] has no effect.
- R3: The mask is ymask_i[5:0]. Data bits whose mask bit is 0 do not affect the result, and ymask_i[6] has no effect.
- R4: After a start with a valid position, eq_o is 1 exactly when every masked data bit of the register character equals the corresponding memory bit.
- R5: After a start with a valid position, cmp_o is 1 exactly when every masked data bit of the register character differs from the corresponding memory bit.
- R6: A start with a non-empty mask and a mixed match leaves both toggles 0, even if they were set before the start.
- R7: A start with a valid position and ymask_i[5:0] = 0 sets both eq_o and cmp_o.
- R8: A start with zsel_i[3:0] greater than 7 leaves both toggles 0, whatever the mask is, including an empty mask.
- R9: The parity bit (bit 6 of each character) never affects the result.
- R10: Without a start, eq_o and cmp_o keep their values while the data, select and mask inputs change.
- R11: done_o is high for exactly the one cycle after the edge that samples start_i. eq_o and cmp_o hold the new result in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Evaluate strobe, one cycle |
| reg_i | input | 56 | Register word, eight 7-bit characters |
| mem_i | input | 56 | Memory word, eight 7-bit characters |
| zsel_i | input | 7 | Position select character, numeric bits [3:0] |
| ymask_i | input | 7 | Mask character, bits [5:0] used |
| eq_o | output | 1 | All masked bits equal |
| cmp_o | output | 1 | All masked bits complementary |
| done_o | output | 1 | Evaluation done pulse |

## Verification
The hardest case to reach is a toggle that has to be cleared when it was already set. A stale value looks correct whenever the previous result happens to match the new one. The vector table is therefore ordered so that results alternate: an empty-mask case that sets both toggles is followed directly by a parity case that expects only the equal toggle. The characters outside the selected position are filled so that they all differ under any mask. A wrong position choice then shows up as a spurious complement result.

// File: rtl/char_cmp_pkg.sv
package char_cmp_pkg;
  localparam int unsigned NUM_W = 4;  // numeric bits of the select character

  typedef struct packed {
    logic eq;
    logic cm;
  } cmp_flags_t;
endpackage

// File: rtl/char_cmp_pick.sv
module char_cmp_pick
  import char_cmp_pkg::*;
#(
  parameter int unsigned N_CHARS = 8,
  parameter int unsigned DATA_W  = 6,
  localparam int unsigned CHAR_W = DATA_W + 1,
  localparam int unsigned WORD_W = N_CHARS * CHAR_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [NUM_W-1:0]  sel_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] chars [N_CHARS];
  logic [N_CHARS-1:0] unused_par;

  for (genvar g = 0; g < N_CHARS; g++) begin : g_slice
    assign chars[g]      = word_i[g*CHAR_W +: DATA_W];
    assign unused_par[g] = word_i[g*CHAR_W + DATA_W];
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < N_CHARS; i++) begin
      if (sel_i == NUM_W'(i)) data_o = chars[i];
    end
  end
endmodule

// File: rtl/char_cmp_eval.sv
module char_cmp_eval #(
  parameter int unsigned DATA_W = 6
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              all_eq_o,
  output logic              all_ne_o
);
  logic [DATA_W-1:0] hit_eq, hit_ne;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    // a bit outside the mask counts as satisfying both conditions
    assign hit_eq[g] = !mask_i[g] || (a_i[g] == b_i[g]);
    assign hit_ne[g] = !mask_i[g] || (a_i[g] != b_i[g]);
  end

  assign all_eq_o = &hit_eq;
  assign all_ne_o = &hit_ne;
endmodule

// File: rtl/char_cmp_flags.sv
module char_cmp_flags
  import char_cmp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pos_ok_i,
  input  logic all_eq_i,
  input  logic all_ne_i,
  output logic eq_o,
  output logic cmp_o,
  output logic done_o
);
  cmp_flags_t flags_q, flags_d;
  logic       done_q;

  always_comb begin
    flags_d = flags_q;
    if (start_i) begin
      // clear-then-evaluate collapses into one load
      flags_d.eq = pos_ok_i && all_eq_i;
      flags_d.cm = pos_ok_i && all_ne_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      done_q  <= start_i;
    end
  end

  assign eq_o   = flags_q.eq;
  assign cmp_o  = flags_q.cm;
  assign done_o = done_q;
endmodule

// File: rtl/char_cmp_unit.sv
module char_cmp_unit
  import char_cmp_pkg::*;
#(
  parameter int unsigned N_CHARS = 8,
  parameter int unsigned DATA_W  = 6,
  localparam int unsigned CHAR_W = DATA_W + 1,
  localparam int unsigned WORD_W = N_CHARS * CHAR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] reg_i,
  input  logic [WORD_W-1:0] mem_i,
  input  logic [CHAR_W-1:0] zsel_i,
  input  logic [CHAR_W-1:0] ymask_i,
  output logic              eq_o,
  output logic              cmp_o,
  output logic              done_o
);
  logic [NUM_W-1:0]  pos;
  logic              pos_ok;
  logic [DATA_W-1:0] reg_ch, mem_ch, mask;
  logic              all_eq, all_ne;
  logic              unused_sel;

  assign pos        = zsel_i[NUM_W-1:0];
  assign pos_ok     = {1'b0, pos} < (NUM_W+1)'(N_CHARS);
  assign mask       = ymask_i[DATA_W-1:0];
  assign unused_sel = ^{zsel_i[CHAR_W-1:NUM_W], ymask_i[CHAR_W-1:DATA_W]};

  char_cmp_pick #(.N_CHARS(N_CHARS), .DATA_W(DATA_W)) u_pick_reg (
    .word_i (reg_i),
    .sel_i  (pos),
    .data_o (reg_ch)
  );

  char_cmp_pick #(.N_CHARS(N_CHARS), .DATA_W(DATA_W)) u_pick_mem (
    .word_i (mem_i),
    .sel_i  (pos),
    .data_o (mem_ch)
  );

  char_cmp_eval #(.DATA_W(DATA_W)) u_eval (
    .a_i      (reg_ch),
    .b_i      (mem_ch),
    .mask_i   (mask),
    .all_eq_o (all_eq),
    .all_ne_o (all_ne)
  );

  char_cmp_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .pos_ok_i (pos_ok),
    .all_eq_i (all_eq),
    .all_ne_i (all_ne),
    .eq_o     (eq_o),
    .cmp_o    (cmp_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/char_cmp_unit_chk.sv
module char_cmp_unit_chk
  import char_cmp_pkg::*;
#(
  parameter int unsigned DATA_W = 6,
  localparam int unsigned CHAR_W = DATA_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CHAR_W-1:0] zsel_i,
  input logic [CHAR_W-1:0] ymask_i,
  input logic              eq_o,
  input logic              cmp_o,
  input logic              done_o
);
  a_r11_done_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  a_r11_done_only_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  a_r10_hold_without_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(eq_o) && $stable(cmp_o)));

  a_r6_not_both_with_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ymask_i[DATA_W-1:0] != '0) |=> !(eq_o && cmp_o));

  a_r7_empty_mask_sets_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && zsel_i[NUM_W-1:0] < NUM_W'(8) && ymask_i[DATA_W-1:0] == '0) |=> (eq_o && cmp_o));

  a_r8_bad_pos_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && zsel_i[NUM_W-1:0] > NUM_W'(7)) |=> (!eq_o && !cmp_o));
endmodule

bind char_cmp_unit char_cmp_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .zsel_i  (zsel_i),
  .ymask_i (ymask_i),
  .eq_o    (eq_o),
  .cmp_o   (cmp_o),
  .done_o  (done_o)
);

// File: tb/char_cmp_unit_bench.sv
`timescale 1ns/1ps
module char_cmp_unit_bench;
  localparam int N_CHARS = 8;
  localparam int CHAR_W  = 7;
  localparam int WORD_W  = N_CHARS * CHAR_W;

  typedef struct packed {
    logic [6:0] z;
    logic [5:0] a;
    logic [5:0] m;
    logic [6:0] y;
    logic       par;
    logic       eq;
    logic       cm;
  } vec_t;

  localparam int N_VEC = 9;
  localparam vec_t VEC [N_VEC] = '{
    '{7'h00, 6'h2A, 6'h2A, 7'h3F, 1'b0, 1'b1, 1'b0},  // R4
    '{7'h07, 6'h2A, 6'h15, 7'h3F, 1'b0, 1'b0, 1'b1},  // R5
    '{7'h03, 6'h0F, 6'h0F, 7'h7F, 1'b0, 1'b1, 1'b0},  // R3 bit 6 ignored
    '{7'h05, 6'h3C, 6'h30, 7'h30, 1'b0, 1'b1, 1'b0},  // R3 masked-off diff
    '{7'h02, 6'h3C, 6'h30, 7'h3F, 1'b0, 1'b0, 1'b0},  // R6
    '{7'h04, 6'h01, 6'h00, 7'h03, 1'b0, 1'b0, 1'b0},  // R6
    '{7'h36, 6'h21, 6'h1E, 7'h21, 1'b0, 1'b0, 1'b1},  // R2 upper select bits
    '{7'h01, 6'h00, 6'h00, 7'h00, 1'b0, 1'b1, 1'b1},  // R7
    '{7'h00, 6'h2A, 6'h2A, 7'h3F, 1'b1, 1'b1, 1'b0}   // R9 + R6 clear of cmp
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [WORD_W-1:0] reg_w = '0;
  logic [WORD_W-1:0] mem_w = '0;
  logic [6:0]        zsel = '0;
  logic [6:0]        ymask = '0;
  logic              eq, cm, done;
  int                n_run = 0;
  int                n_fail = 0;

  always #2 clk = ~clk;

  char_cmp_unit u_char_cmp_unit (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .reg_i   (reg_w),
    .mem_i   (mem_w),
    .zsel_i  (zsel),
    .ymask_i (ymask),
    .eq_o    (eq),
    .cmp_o   (cm),
    .done_o  (done)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // background: all other characters differ in every data bit
  task automatic load(input logic [6:0] z, input logic [5:0] a, input logic [5:0] m,
                      input logic par);
    for (int j = 0; j < N_CHARS; j++) begin
      reg_w[j*CHAR_W +: CHAR_W] = {1'b1, 6'h00};
      mem_w[j*CHAR_W +: CHAR_W] = {1'b0, 6'h3F};
    end
    if (z[3:0] < 4'd8) begin
      reg_w[z[2:0]*CHAR_W +: CHAR_W] = {par, a};
      mem_w[z[2:0]*CHAR_W +: CHAR_W] = {1'b0, m};
    end
    zsel = z;
  endtask

  task automatic run(input string req, input logic [6:0] z, input logic [5:0] a,
                     input logic [5:0] m, input logic [6:0] y, input logic par,
                     input logic e_eq, input logic e_cm);
    @(negedge clk);
    load(z, a, m, par);
    ymask = y;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " eq"}, eq, e_eq);
    check({req, " cmp"}, cm, e_cm);
    check("R11 done pulse", done, 1'b1);
    @(negedge clk);
    check("R11 done drops", done, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1;
    check("R1 eq in reset", eq, 1'b0);
    check("R1 cmp in reset", cm, 1'b0);
    check("R1 done in reset", done, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 eq after reset", eq, 1'b0);
    check("R1 cmp after reset", cm, 1'b0);
    check("R1 done after reset", done, 1'b0);

    for (int i = 0; i < N_VEC; i++)
      run($sformatf("vec%0d", i), VEC[i].z, VEC[i].a, VEC[i].m, VEC[i].y,
          VEC[i].par, VEC[i].eq, VEC[i].cm);

    // R8: invalid position wins over an empty mask
    run("R7 set both", 7'h06, 6'h11, 6'h22, 7'h00, 1'b0, 1'b1, 1'b1);
    run("R8 empty mask", 7'h08, 6'h00, 6'h00, 7'h00, 1'b0, 1'b0, 1'b0);
    run("R8 full mask", 7'h0F, 6'h00, 6'h00, 7'h3F, 1'b0, 1'b0, 1'b0);

    // R10: hold without start
    run("R4 equal before hold", 7'h02, 6'h15, 6'h15, 7'h3F, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    load(7'h02, 6'h15, 6'h2A, 1'b0);
    ymask = 7'h00;
    repeat (3) @(negedge clk);
    check("R10 eq holds", eq, 1'b1);
    check("R10 cmp holds", cm, 1'b0);
    check("R11 no done without start", done, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule